// File: doc/BRIEF.md
# Lattice-Reduction Loop Sequencer

This block is the control engine of a complex lattice-reduction processor that works on a small upper-triangular channel matrix. It does none of the arithmetic itself. It walks a column index k and a row index n through the size-reduction and basis-update phases. It hands one command at a time to an external datapath and reads back that datapath's comparison verdicts: a relaxed-bound violation, an absolute-bound violation and the exchange (swap) verdict.

The size condition is relaxed. The reduction against the row directly above the diagonal (n = k−1) always runs. Every row further up is first probed. A reduction for that row follows only when the datapath reports that the real or imaginary part has reached three halves of the diagonal magnitude, or has reached half the absolute bound. After the rows of a column, a check command asks whether three quarters of the squared upper diagonal exceeds the energy of the lower 2×2 column. If it does, an exchange command swaps the two columns, rotates the two rows and steps k back to no lower than 2. Otherwise k advances. When k passes the matrix dimension, the block pulses done and reports how many cycles the matrix took.

Top module: `lr_sequencer`

## Requirements
- R1: After reset, cmd_valid_o, busy_o and done_o are low and cycles_o is zero.
- R2: A start_i seen while idle is accepted. The first command, a reduction with column 2 and row 1, is issued in the cycle after that. A start_i seen while busy has no effect on the command stream.
- R3: Each visit to a column k begins with an unconditional reduction command for row k−1. No probe is ever issued for row k−1.
- R4: For rows n = k−2 down to 1, a probe command is issued. A reduction of the same row follows it only if relax_viol_i or abs_viol_i was high with the probe's dp_ready_i. Otherwise the next row, or the check, follows.
- R5: After the rows, a check command with row k−1 is issued. If swap_req_i is high with its dp_ready_i, an exchange command for the same column follows, and the next column is max(k−1, 2).
- R6: If the check returns no swap, the column becomes k+1. The run ends when that value exceeds DIM. Column indices of issued commands stay within 2..DIM.
- R7: Exactly one command is outstanding. cmd_valid_o is a one-cycle pulse. dp_ready_i and the flags are only sampled in the cycles after a command is issued, and the next command appears in the cycle after the accepted dp_ready_i.
- R8: done_o is a one-cycle pulse in the cycle after the final dp_ready_i. In that cycle cycles_o shows the number of busy cycles of the run, and it holds that value until the next done.
- R9: Command codes on cmd_op_o: 0 = reduce, 1 = probe, 2 = check, 3 = exchange. For check and exchange, cmd_row_o carries k−1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin processing a matrix |
| dp_ready_i | input | 1 | Datapath finished the outstanding command |
| relax_viol_i | input | 1 | Probe verdict: part reached 3/2 of the diagonal magnitude |
| abs_viol_i | input | 1 | Probe verdict: part reached the absolute half-bound |
| swap_req_i | input | 1 | Check verdict: column exchange required |
| cmd_valid_o | output | 1 | Command issued this cycle |
| cmd_op_o | output | 2 | Command code (see R9) |
| cmd_col_o | output | LR_IDX_W | Column index k |
| cmd_row_o | output | LR_IDX_W | Row index n |
| busy_o | output | 1 | A matrix is in progress |
| done_o | output | 1 | Matrix finished (one cycle) |
| cycles_o | output | CNT_W | Busy cycles of the last matrix |

## Verification
The embedded properties watch, on every cycle, the one-cycle width of command and done pulses, the ranges of the column and row indices, the rule that no probe targets row k−1, that an exchange only follows a check, and the entry command after start. The order of the command stream, the conditional reductions driven by the two violation flags, the step-back to column 2 on an early swap, and the exact cycle count can only be shown by the bench's scenarios. Its behavioural model replays the algorithm with varying datapath latencies, spurious ready pulses during issue, and start pulses while busy.

// File: rtl/lr_seq_pkg.sv
package lr_seq_pkg;

    localparam int LR_IDX_W = 4;

    typedef logic [LR_IDX_W-1:0] lr_idx_t;

    typedef enum logic [1:0] {
        OP_REDUCE   = 2'd0,
        OP_PROBE    = 2'd1,
        OP_CHECK    = 2'd2,
        OP_EXCHANGE = 2'd3
    } lr_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } lr_state_e;

    typedef struct packed {
        lr_op_e  op;
        lr_idx_t col;
        lr_idx_t row;
    } lr_cmd_t;

    typedef struct packed {
        logic relax;
        logic absb;
        logic swap;
    } lr_flags_t;

    // Column after an exchange: one back, never below 2.
    function automatic lr_idx_t col_step_back(lr_idx_t k);
        return (k > lr_idx_t'(2)) ? lr_idx_t'(k - 1'b1) : lr_idx_t'(2);
    endfunction

    function automatic lr_cmd_t make_cmd(lr_op_e op, lr_idx_t col, lr_idx_t row);
        lr_cmd_t c;
        c.op  = op;
        c.col = col;
        c.row = row;
        return c;
    endfunction

endpackage

// File: rtl/lr_step_decider.sv
module lr_step_decider
    import lr_seq_pkg::*;
#(
    parameter int DIM = 4
) (
    input  lr_cmd_t   cur_i,
    input  lr_flags_t flags_i,
    output lr_cmd_t   nxt_o,
    output logic      finish_o
);
    localparam lr_idx_t LAST_COL = lr_idx_t'(DIM);

    lr_idx_t k_dn;
    lr_idx_t k_up;
    lr_idx_t n_dn;
    lr_cmd_t to_check;

    always_comb begin
        k_dn     = col_step_back(cur_i.col);
        k_up     = lr_idx_t'(cur_i.col + 1'b1);
        n_dn     = lr_idx_t'(cur_i.row - 1'b1);
        to_check = make_cmd(OP_CHECK, cur_i.col, lr_idx_t'(cur_i.col - 1'b1));
        nxt_o    = cur_i;
        finish_o = 1'b0;
        unique case (cur_i.op)
            OP_REDUCE: begin
                if (cur_i.row > lr_idx_t'(1))
                    nxt_o = make_cmd(OP_PROBE, cur_i.col, n_dn);
                else
                    nxt_o = to_check;
            end
            OP_PROBE: begin
                if (flags_i.relax || flags_i.absb)
                    nxt_o = make_cmd(OP_REDUCE, cur_i.col, cur_i.row);
                else if (cur_i.row > lr_idx_t'(1))
                    nxt_o = make_cmd(OP_PROBE, cur_i.col, n_dn);
                else
                    nxt_o = to_check;
            end
            OP_CHECK: begin
                if (flags_i.swap)
                    nxt_o = make_cmd(OP_EXCHANGE, cur_i.col, cur_i.row);
                else if (cur_i.col >= LAST_COL)
                    finish_o = 1'b1;
                else
                    nxt_o = make_cmd(OP_REDUCE, k_up, cur_i.col);
            end
            OP_EXCHANGE: begin
                nxt_o = make_cmd(OP_REDUCE, k_dn, lr_idx_t'(k_dn - 1'b1));
            end
            default: nxt_o = cur_i;
        endcase
    end
endmodule

// File: rtl/lr_cycle_meter.sv
module lr_cycle_meter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear_i,
    input  logic             count_i,
    input  logic             capture_i,
    output logic [CNT_W-1:0] cycles_o
);
    logic [CNT_W-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt  <= '0;
            cycles_o <= '0;
        end else begin
            if (clear_i)
                run_cnt <= '0;
            else if (count_i)
                run_cnt <= run_cnt + 1'b1;
            if (capture_i)
                cycles_o <= run_cnt + 1'b1;
        end
    end

    // R8: the captured count is never zero once a run completed
    assert_capture_nonzero_R8: assert property (@(posedge clk) disable iff (rst)
        capture_i |=> (cycles_o != '0));
endmodule

// File: rtl/lr_seq_ctrl.sv
module lr_seq_ctrl
    import lr_seq_pkg::*;
#(
    parameter int DIM = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start_i,
    input  logic      ready_i,
    input  lr_flags_t flags_i,
    output lr_cmd_t   cmd_o,
    output logic      cmd_valid_o,
    output logic      busy_o,
    output logic      accept_o,
    output logic      capture_o,
    output logic      done_o
);
    lr_state_e state;
    lr_cmd_t   cmd_q;
    lr_cmd_t   nxt_cmd;
    logic      finish;
    logic      take_ready;

    lr_step_decider #(.DIM(DIM)) decider_i (
        .cur_i    (cmd_q),
        .flags_i  (flags_i),
        .nxt_o    (nxt_cmd),
        .finish_o (finish)
    );

    assign accept_o    = (state == ST_IDLE) && start_i;
    assign take_ready  = (state == ST_WAIT) && ready_i;
    assign capture_o   = take_ready && finish;
    assign cmd_valid_o = (state == ST_ISSUE);
    assign busy_o      = (state != ST_IDLE);
    assign cmd_o       = cmd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            cmd_q  <= make_cmd(OP_REDUCE, lr_idx_t'(2), lr_idx_t'(1));
            done_o <= 1'b0;
        end else begin
            done_o <= capture_o;
            unique case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        cmd_q <= make_cmd(OP_REDUCE, lr_idx_t'(2), lr_idx_t'(1));
                        state <= ST_ISSUE;
                    end
                end
                ST_ISSUE: state <= ST_WAIT;
                ST_WAIT: begin
                    if (ready_i) begin
                        if (finish) begin
                            state <= ST_IDLE;
                        end else begin
                            cmd_q <= nxt_cmd;
                            state <= ST_ISSUE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    initial begin
        assert_dim_fits_R6: assert (DIM >= 2 && DIM < (1 << LR_IDX_W));
    end

    assert_cmd_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        cmd_valid_o |=> !cmd_valid_o);

    assert_col_range_R6: assert property (@(posedge clk) disable iff (rst)
        cmd_valid_o |-> (cmd_o.col >= lr_idx_t'(2) && cmd_o.col <= lr_idx_t'(DIM)));

    assert_row_range_R4: assert property (@(posedge clk) disable iff (rst)
        cmd_valid_o |-> (cmd_o.row >= lr_idx_t'(1) && cmd_o.row < cmd_o.col));

    assert_no_probe_top_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid_o && cmd_o.op == OP_PROBE) |-> (cmd_o.row < lr_idx_t'(cmd_o.col - 1'b1)));

    assert_exchange_after_check_R5: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid_o && cmd_o.op == OP_EXCHANGE) |-> $past(cmd_o.op == OP_CHECK && ready_i));

    assert_entry_cmd_R2: assert property (@(posedge clk) disable iff (rst)
        accept_o |=> (cmd_valid_o && cmd_o.op == OP_REDUCE
                      && cmd_o.col == lr_idx_t'(2) && cmd_o.row == lr_idx_t'(1)));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);
endmodule

// File: rtl/lr_sequencer.sv
module lr_sequencer
    import lr_seq_pkg::*;
#(
    parameter int DIM   = 4,
    parameter int CNT_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic                dp_ready_i,
    input  logic                relax_viol_i,
    input  logic                abs_viol_i,
    input  logic                swap_req_i,
    output logic                cmd_valid_o,
    output logic [1:0]          cmd_op_o,
    output logic [LR_IDX_W-1:0] cmd_col_o,
    output logic [LR_IDX_W-1:0] cmd_row_o,
    output logic                busy_o,
    output logic                done_o,
    output logic [CNT_W-1:0]    cycles_o
);
    lr_flags_t flags;
    lr_cmd_t   cmd;
    logic      accept;
    logic      capture;

    assign flags.relax = relax_viol_i;
    assign flags.absb  = abs_viol_i;
    assign flags.swap  = swap_req_i;

    lr_seq_ctrl #(.DIM(DIM)) ctrl_i (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .ready_i     (dp_ready_i),
        .flags_i     (flags),
        .cmd_o       (cmd),
        .cmd_valid_o (cmd_valid_o),
        .busy_o      (busy_o),
        .accept_o    (accept),
        .capture_o   (capture),
        .done_o      (done_o)
    );

    lr_cycle_meter #(.CNT_W(CNT_W)) meter_i (
        .clk       (clk),
        .rst       (rst),
        .clear_i   (accept),
        .count_i   (busy_o),
        .capture_i (capture),
        .cycles_o  (cycles_o)
    );

    assign cmd_op_o  = cmd.op;
    assign cmd_col_o = cmd.col;
    assign cmd_row_o = cmd.row;
endmodule

// File: tb/lr_sequencer_tb_top.sv
`timescale 1ns/1ps
module lr_sequencer_tb_top;
    localparam int DIM = 4;
    localparam int IW  = lr_seq_pkg::LR_IDX_W;
    localparam int CW  = 16;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst = 1'b1;
    logic start_i = 1'b0, dp_ready_i = 1'b0;
    logic relax_viol_i = 1'b0, abs_viol_i = 1'b0, swap_req_i = 1'b0;
    logic          cmd_valid_o, busy_o, done_o;
    logic [1:0]    cmd_op_o;
    logic [IW-1:0] cmd_col_o, cmd_row_o;
    logic [CW-1:0] cycles_o;

    lr_sequencer #(.DIM(DIM), .CNT_W(CW)) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .dp_ready_i(dp_ready_i),
        .relax_viol_i(relax_viol_i), .abs_viol_i(abs_viol_i), .swap_req_i(swap_req_i),
        .cmd_valid_o(cmd_valid_o), .cmd_op_o(cmd_op_o), .cmd_col_o(cmd_col_o),
        .cmd_row_o(cmd_row_o), .busy_o(busy_o), .done_o(done_o), .cycles_o(cycles_o)
    );

    int unsigned vectors = 0, miscompares = 0;
    bit          finished = 0;
    int unsigned e_cycles = 0;
    int unsigned busy_cnt = 0;
    int unsigned lcg = 32'h1234_5678;
    int          lat_mode = 1;
    bit          noise = 0;
    logic [31:0] viol_pat = '0;
    int          probe_idx = 0;
    bit          swap_q[$];

    task automatic chk(string tag, string what, int act, int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // One cycle: compare outputs at the falling edge against the model.
    task automatic step(bit v, int op, int k, int n, bit b, bit d, string tag);
        @(negedge clk);
        chk(tag, "cmd_valid", int'(cmd_valid_o), int'(v));
        if (v) begin
            chk("R9", "cmd_op", int'(cmd_op_o), op);
            chk(tag, "cmd_col", int'(cmd_col_o), k);
            chk(tag, "cmd_row", int'(cmd_row_o), n);
        end
        chk("R2", "busy", int'(busy_o), int'(b));
        chk("R8", "done", int'(done_o), int'(d));
        chk("R8", "cycles", int'(cycles_o), int'(e_cycles));
    endtask

    task automatic drive(bit s, bit r, logic [2:0] f);
        start_i = s; dp_ready_i = r;
        relax_viol_i = f[2]; abs_viol_i = f[1]; swap_req_i = f[0];
    endtask

    // Issue cycle, latency wait, accepting ready with the given verdicts.
    task automatic issue(string tag, int op, int k, int n, logic [2:0] f);
        int lat;
        lcg = lcg * 32'd1103515245 + 32'd12345;
        lat = 1 + int'((lcg >> 16) % lat_mode);
        step(1, op, k, n, 1, 0, tag); busy_cnt++;
        // R7: ready and flags during the issue cycle must be ignored; R2: start while busy too
        drive(noise, noise, noise ? 3'b111 : 3'b000);
        for (int w = 1; w < lat; w++) begin
            step(0, 0, 0, 0, 1, 0, tag); busy_cnt++;
            drive(noise, 1'b0, noise ? 3'b111 : 3'b000);
        end
        step(0, 0, 0, 0, 1, 0, tag); busy_cnt++;
        drive(1'b0, 1'b1, f);
    endtask

    task automatic run_matrix(string tag);
        int  k;
        bit  r, a, sw;
        step(0, 0, 0, 0, 0, 0, "R2");
        drive(1'b1, 1'b0, 3'b000);
        busy_cnt = 0; probe_idx = 0; k = 2;
        while (k <= DIM) begin
            issue("R3", 0, k, k - 1, 3'b110);
            for (int n = k - 2; n >= 1; n--) begin
                r = viol_pat[(2 * probe_idx) % 32];
                a = viol_pat[(2 * probe_idx + 1) % 32];
                probe_idx++;
                issue("R4", 1, k, n, {r, a, 1'b1});
                if (r || a) issue("R4", 0, k, n, 3'b001);
            end
            sw = 0;
            if (swap_q.size() > 0) sw = swap_q.pop_front();
            issue("R5", 2, k, k - 1, {2'b11, sw});
            if (sw) begin
                issue("R5", 3, k, k - 1, 3'b111);
                k = (k > 2) ? k - 1 : 2;
            end else begin
                k++;
            end
        end
        e_cycles = busy_cnt;
        step(0, 0, 0, 0, 0, 1, {tag, " R8"});
        drive(1'b0, 1'b0, 3'b000);
        step(0, 0, 0, 0, 0, 0, "R8");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        step(0, 0, 0, 0, 0, 0, "R1");

        // R6: no violations, no swaps, unit latency
        lat_mode = 1; noise = 0; viol_pat = '0;
        run_matrix("R6");

        // R4: every probe reports a relaxed-bound violation
        lat_mode = 3; viol_pat = 32'h5555_5555;
        run_matrix("R4");

        // R5: absolute-bound only, swaps including one at column 2
        viol_pat = 32'hAAAA_AAAA;
        swap_q = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
        run_matrix("R5");

        // R7 / R2: spurious ready in issue cycles, start while busy
        lat_mode = 4; noise = 1; viol_pat = 32'h0000_0936;
        swap_q = '{1'b0, 1'b0, 1'b1};
        run_matrix("R7");

        // back-to-back runs with mixed patterns
        noise = 0; lat_mode = 2; viol_pat = 32'h0000_0024;
        swap_q = '{1'b0, 1'b1};
        run_matrix("R3");

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL R7 watchdog: actual hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule